// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

The controller gathers interrupt requests from a fixed set of device sources, each tied to its own urgency level, and gives the processor core a single request line and a vector index. It keeps a current-priority register. A source is offered to the core only if its level is strictly above that priority, so a running handler can be preempted only by something more urgent. When the core takes an interrupt, the controller saves the current priority and mode on a small stack. It then raises the priority to the level being serviced, clears the global enable and enters supervisor mode. A return-from-exception pulse restores the saved priority and mode.

A non-maskable source, the power-fail line, sits above every maskable level. It is latched on its rising edge and is offered whatever the enable, mask and priority are. Software running in supervisor mode can clear pending bits, set the per-source mask, set the global enable and mode, and load the priority register. Saving registers and running handlers are left to the core.

With default parameters the five maskable sources have levels 0, 2, 4, 5 and 6. In index order they are a software request, network, sound, disk and a real-time clock. The non-maskable source has level 7 and vector 5.

Top module: `pic_ctrl`

## Requirements
- R1: A high `src_req[i]` at a clock edge sets `pending[i]`. The bit stays set until a supervisor write with `wr_sel`=0 has a 1 in bit i of `wr_data`. If the request is still high at the same edge, the set wins over the clear.
- R2: `irq_req` is high when the non-maskable event is pending, or when `glob_en` is 1 and at least one source is eligible. A source is eligible when it is pending, its mask bit is 1 (set by a write with `wr_sel`=1) and its level is above `cur_prio`. `irq_vec` gives the index of the eligible source with the highest level. Both outputs reflect the state after the same edge that changed it.
- R3: A source whose level is equal to or below `cur_prio` is never offered to the core.
- R4: An `int_ack` while `irq_req` is high pushes {`cur_prio`, `super_mode`}. It sets `cur_prio` to the level of `irq_vec`, clears `glob_en` and sets `super_mode`. An `int_ack` while `irq_req` is low is ignored.
- R5: An `int_rte` with no accepted `int_ack` at the same edge pops the stack and restores `cur_prio` and `super_mode`. On an empty stack the pulse is ignored. `glob_en` is not restored.
- R6: After the handler sets `glob_en`, a source with a higher level than the one being serviced still raises `irq_req` and preempts it.
- R7: A rising edge on `nmi_req` latches a non-maskable event. It is offered with vector NUM_SRC regardless of `glob_en`, mask and `cur_prio`, and it wins over all sources. Taking it sets `cur_prio` to all ones and clears the event.
- R8: The save stack holds 4 entries. A push onto a full stack drops the entry but still updates the priority, and it sets `stack_err`, which stays set until reset.
- R9: Writes take effect only while `super_mode` is 1. `wr_sel`=2 sets `glob_en` from bit 0 and `super_mode` from bit 1, and `wr_sel`=3 loads `cur_prio` from the low bits. An accepted ack, or else a pop, overrides a write with `wr_sel` 2 or 3 at the same edge.
- R10: After reset, `irq_req`, `pending`, `cur_prio`, `glob_en` and `stack_err` are 0, `super_mode` is 1, every mask bit is 1 and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Level requests from the maskable sources |
| nmi_req | input | 1 | Non-maskable request, edge sensitive |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 clear, 1 mask, 2 enable/mode, 3 priority |
| wr_data | input | DATA_W | Write data |
| int_ack | input | 1 | Core takes the offered interrupt |
| int_rte | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector index of the offered interrupt |
| cur_prio | output | LVL_W | Current processor priority |
| glob_en | output | 1 | Global interrupt enable |
| super_mode | output | 1 | 1 in supervisor mode, 0 in user mode |
| stack_err | output | 1 | Sticky save-stack overflow flag |
| pending | output | NUM_SRC | Latched pending bits |

## Verification
Every result is registered and computed from next-state values, so a request, write, ack or return that is stable at edge k is visible on the outputs right after edge k. This includes the re-evaluated `irq_req` and `irq_vec`. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the next one. A reference model in the bench updates on the same edge, so each comparison lines up with the edge that caused the change. Directed sequences cover nesting, an empty-stack return, user-mode writes, set-versus-clear and overflow. Random traffic is then compared cycle by cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    WR_CLR  = 2'd0,
    WR_MASK = 2'd1,
    WR_EN   = 2'd2,
    WR_PRIO = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/pic_pend.sv
module pic_pend #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] clr_bits,
  input  logic               nmi_req,
  input  logic               nmi_take,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] pend_n,
  output logic               nmi_n
);
  logic nmi_prev_q;
  logic nmi_q;

  // a held request re-sets its bit in the same cycle it is cleared
  assign pend_n = (pend_q & ~clr_bits) | src_req;
  assign nmi_n  = (nmi_q & ~nmi_take) | (nmi_req & ~nmi_prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      nmi_q      <= 1'b0;
      nmi_prev_q <= 1'b0;
    end else begin
      pend_q     <= pend_n;
      nmi_q      <= nmi_n;
      nmi_prev_q <= nmi_req;
    end
  end
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int                     NUM_SRC = 5,
  parameter int                     LVL_W   = 3,
  parameter int                     VEC_W   = 3,
  parameter logic [NUM_SRC*LVL_W-1:0] LEVELS = '0
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [LVL_W-1:0]   prio,
  output logic               hit,
  output logic [VEC_W-1:0]   idx
);
  logic [LVL_W-1:0] best;

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && mask[i] && (LEVELS[i*LVL_W +: LVL_W] > prio)) begin
        if (!hit || (LEVELS[i*LVL_W +: LVL_W] >= best)) begin
          hit  = 1'b1;
          idx  = VEC_W'(i);
          best = LEVELS[i*LVL_W +: LVL_W];
        end
      end
    end
  end
endmodule

// File: rtl/pic_stack.sv
module pic_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [IDX_W-1:0] rd_idx;

  assign empty  = (sp_q == '0);
  assign full   = (sp_q == SP_W'(DEPTH));
  assign rd_idx = IDX_W'(sp_q - 1'b1);
  assign dout   = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push && !full) mem[IDX_W'(sp_q)] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)                   sp_q <= '0;
    else if (push && !full)    sp_q <= sp_q + 1'b1;
    else if (pop && !push && !empty) sp_q <= sp_q - 1'b1;
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int                       NUM_SRC     = 5,
  parameter int                       LVL_W       = 3,
  parameter int                       STACK_DEPTH = 4,
  parameter logic [NUM_SRC*LVL_W-1:0] LEVELS      = {3'd6, 3'd5, 3'd4, 3'd2, 3'd0},
  parameter int                       VEC_W       = $clog2(NUM_SRC + 1),
  parameter int                       DATA_W      = (NUM_SRC > LVL_W) ? NUM_SRC : LVL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               nmi_req,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               int_ack,
  input  logic               int_rte,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [LVL_W-1:0]   cur_prio,
  output logic               glob_en,
  output logic               super_mode,
  output logic               stack_err,
  output logic [NUM_SRC-1:0] pending
);
  import pic_pkg::*;

  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);
  localparam logic [LVL_W-1:0] NMI_LVL = '1;
  localparam int               FRM_W   = LVL_W + 1;

  logic [NUM_SRC-1:0] mask_q, mask_n, clr_bits, pend_n;
  logic               nmi_n, take, take_nmi, wr_ok, do_pop;
  logic [LVL_W-1:0]   prio_n, take_lvl;
  logic               en_n, sup_n, err_n, irq_n, hit;
  logic [VEC_W-1:0]   vec_n, arb_idx;
  logic [FRM_W-1:0]   frm_out;
  logic               stk_empty, stk_full;
  wr_sel_e            sel;

  function automatic logic [LVL_W-1:0] level_of(input logic [VEC_W-1:0] v);
    logic [LVL_W-1:0] r;
    r = NMI_LVL;
    for (int i = 0; i < NUM_SRC; i++)
      if (v == VEC_W'(i)) r = LEVELS[i*LVL_W +: LVL_W];
    return r;
  endfunction

  assign sel      = wr_sel_e'(wr_sel);
  assign take     = int_ack & irq_req;
  assign take_nmi = take & (irq_vec == NMI_VEC);
  assign take_lvl = level_of(irq_vec);
  assign wr_ok    = wr_en & super_mode;
  assign do_pop   = int_rte & ~take & ~stk_empty;
  assign clr_bits = (wr_ok && sel == WR_CLR) ? wr_data[NUM_SRC-1:0] : '0;
  assign mask_n   = (wr_ok && sel == WR_MASK) ? wr_data[NUM_SRC-1:0] : mask_q;
  assign err_n    = stack_err | (take & stk_full);

  always_comb begin
    prio_n = cur_prio;
    en_n   = glob_en;
    sup_n  = super_mode;
    if (take) begin
      prio_n = take_lvl;
      en_n   = 1'b0;
      sup_n  = 1'b1;
    end else if (do_pop) begin
      {prio_n, sup_n} = frm_out;
    end else if (wr_ok && sel == WR_EN) begin
      en_n  = wr_data[0];
      sup_n = wr_data[1];
    end else if (wr_ok && sel == WR_PRIO) begin
      prio_n = wr_data[LVL_W-1:0];
    end
  end

  pic_pend #(.NUM_SRC(NUM_SRC)) pend_i (
    .clk(clk), .rst(rst), .src_req(src_req), .clr_bits(clr_bits),
    .nmi_req(nmi_req), .nmi_take(take_nmi),
    .pend_q(pending), .pend_n(pend_n), .nmi_n(nmi_n)
  );

  pic_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .LEVELS(LEVELS)) arb_i (
    .pend(pend_n), .mask(mask_n), .prio(prio_n), .hit(hit), .idx(arb_idx)
  );

  pic_stack #(.DEPTH(STACK_DEPTH), .W(FRM_W)) stk_i (
    .clk(clk), .rst(rst), .push(take), .pop(do_pop),
    .din({cur_prio, super_mode}), .dout(frm_out),
    .empty(stk_empty), .full(stk_full)
  );

  assign irq_n = nmi_n | (en_n & hit);
  assign vec_n = nmi_n ? NMI_VEC : arb_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '1;
      cur_prio   <= '0;
      glob_en    <= 1'b0;
      super_mode <= 1'b1;
      stack_err  <= 1'b0;
      irq_req    <= 1'b0;
      irq_vec    <= '0;
    end else begin
      mask_q     <= mask_n;
      cur_prio   <= prio_n;
      glob_en    <= en_n;
      super_mode <= sup_n;
      stack_err  <= err_n;
      irq_req    <= irq_n;
      irq_vec    <= vec_n;
    end
  end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int                       NUM_SRC     = 5,
  parameter int                       LVL_W       = 3,
  parameter int                       STACK_DEPTH = 4,
  parameter logic [NUM_SRC*LVL_W-1:0] LEVELS      = '0,
  parameter int                       VEC_W       = 3,
  parameter int                       DATA_W      = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_req,
  input logic               nmi_req,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic [DATA_W-1:0]  wr_data,
  input logic               int_ack,
  input logic               int_rte,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec,
  input logic [LVL_W-1:0]   cur_prio,
  input logic               glob_en,
  input logic               super_mode,
  input logic               stack_err,
  input logic [NUM_SRC-1:0] pending
);
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);

  function automatic logic [LVL_W-1:0] lvl(input logic [VEC_W-1:0] v);
    logic [LVL_W-1:0] r;
    r = '1;
    for (int i = 0; i < NUM_SRC; i++)
      if (v == VEC_W'(i)) r = LEVELS[i*LVL_W +: LVL_W];
    return r;
  endfunction

  assert_irq_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_vec != NMI_VEC) |-> glob_en);

  assert_lvl_above_prio_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_vec != NMI_VEC) |-> (lvl(irq_vec) > cur_prio));

  assert_ack_enters_sup_R4: assert property (@(posedge clk) disable iff (rst)
    (int_ack && irq_req) |=> (super_mode && !glob_en));

  assert_nmi_edge_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_req) |=> (irq_req && irq_vec == NMI_VEC));

  assert_nmi_prio_R7: assert property (@(posedge clk) disable iff (rst)
    (int_ack && irq_req && irq_vec == NMI_VEC) |=> (cur_prio == '1));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    stack_err |=> stack_err);

  assert_user_wr_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !super_mode && !int_ack && !int_rte)
      |=> ($stable(cur_prio) && $stable(glob_en) && !super_mode));
endmodule

bind pic_ctrl pic_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .STACK_DEPTH(STACK_DEPTH),
  .LEVELS(LEVELS), .VEC_W(VEC_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/pic_ctrl_tb_top.sv
module pic_ctrl_tb_top;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_req = '0;
  logic nmi_req = 1'b0, wr_en = 1'b0, int_ack = 1'b0, int_rte = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [N-1:0] wr_data = '0;
  logic irq_req, glob_en, super_mode, stack_err;
  logic [2:0] irq_vec, cur_prio;
  logic [N-1:0] pending;

  int errors = 0, checks = 0, cycles = 0;

  pic_ctrl dut_i (
    .clk(clk), .rst(rst), .src_req(src_req), .nmi_req(nmi_req),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .int_ack(int_ack), .int_rte(int_rte), .irq_req(irq_req), .irq_vec(irq_vec),
    .cur_prio(cur_prio), .glob_en(glob_en), .super_mode(super_mode),
    .stack_err(stack_err), .pending(pending)
  );

  always #2 clk = ~clk;

  // reference model
  logic [N-1:0] m_pend, m_mask;
  logic [2:0] m_prio, m_vec;
  logic m_en, m_sup, m_err, m_irq, m_nmi, m_nmi_prev;
  logic [3:0] m_stk [4];
  int m_sp;

  function automatic logic [2:0] lvl(input logic [2:0] v);
    case (v)
      3'd0: return 3'd0;
      3'd1: return 3'd2;
      3'd2: return 3'd4;
      3'd3: return 3'd5;
      3'd4: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pend = '0; m_mask = '1; m_prio = '0; m_en = 0; m_sup = 1; m_err = 0;
      m_irq = 0; m_vec = '0; m_nmi = 0; m_nmi_prev = 0; m_sp = 0;
    end else begin
      logic took, okw;
      logic [2:0] best_l;
      int best;
      took = int_ack && m_irq;
      okw  = wr_en && m_sup;
      if (okw && wr_sel == 2'd0) m_pend = m_pend & ~wr_data;
      m_pend = m_pend | src_req;
      if (okw && wr_sel == 2'd1) m_mask = wr_data;
      if (took && m_vec == 3'd5) m_nmi = 0;
      if (nmi_req && !m_nmi_prev) m_nmi = 1;
      m_nmi_prev = nmi_req;
      if (took) begin
        if (m_sp == 4) m_err = 1;
        else begin m_stk[m_sp] = {m_prio, m_sup}; m_sp++; end
        m_prio = lvl(m_vec); m_en = 0; m_sup = 1;
      end else if (int_rte && m_sp > 0) begin
        m_sp--; {m_prio, m_sup} = m_stk[m_sp];
      end else if (okw && wr_sel == 2'd2) begin
        m_en = wr_data[0]; m_sup = wr_data[1];
      end else if (okw && wr_sel == 2'd3) begin
        m_prio = wr_data[2:0];
      end
      best = -1; best_l = '0;
      for (int i = N-1; i >= 0; i--)
        if (m_pend[i] && m_mask[i] && lvl(3'(i)) > m_prio && (best < 0 || lvl(3'(i)) > best_l)) begin
          best = i; best_l = lvl(3'(i));
        end
      m_irq = m_nmi || (m_en && best >= 0);
      m_vec = m_nmi ? 3'd5 : (best >= 0 ? 3'(best) : 3'd0);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R2 irq_req", irq_req, m_irq);
    if (m_irq) chk("R2 irq_vec", irq_vec, m_vec);
    chk("R4 cur_prio", cur_prio, m_prio);
    chk("R4 glob_en", glob_en, m_en);
    chk("R5 super_mode", super_mode, m_sup);
    chk("R8 stack_err", stack_err, m_err);
    chk("R1 pending", pending, m_pend);
  endtask

  task automatic idle();
    src_req = '0; nmi_req = 0; wr_en = 0; int_ack = 0; int_rte = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    cmp_model();
    idle();
  endtask

  task automatic wr(input logic [1:0] s, input logic [N-1:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; cyc();
  endtask

  task automatic nmi_take();
    nmi_req = 1; cyc();
    chk("R7 nmi vec", irq_vec, 5);
    int_ack = 1; cyc();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R10 reset state
    chk("R10 irq", irq_req, 0); chk("R10 prio", cur_prio, 0);
    chk("R10 en", glob_en, 0); chk("R10 sup", super_mode, 1);
    chk("R10 err", stack_err, 0); chk("R10 pend", pending, 0);

    wr(2'd2, 5'b00011);                    // enable, stay supervisor
    src_req = 5'b00010; cyc();              // network, level 2
    chk("R1 latch", pending[1], 1); chk("R2 irq", irq_req, 1); chk("R2 vec", irq_vec, 1);
    int_ack = 1; cyc();
    chk("R4 prio", cur_prio, 2); chk("R4 en", glob_en, 0); chk("R4 irq", irq_req, 0);
    wr(2'd2, 5'b00011);
    chk("R3 same level blocked", irq_req, 0);
    src_req = 5'b01000; cyc();              // disk, level 5
    chk("R6 preempt", irq_req, 1); chk("R6 vec", irq_vec, 3);
    int_ack = 1; cyc();
    chk("R4 nested prio", cur_prio, 5);
    int_rte = 1; cyc(); chk("R5 pop prio", cur_prio, 2);
    int_rte = 1; cyc(); chk("R5 pop prio", cur_prio, 0);
    wr(2'd2, 5'b00001);                     // enable, drop to user
    chk("R2 highest wins", irq_vec, 3); chk("R9 user", super_mode, 0);
    wr(2'd3, 5'b00111);
    chk("R9 prio write ignored", cur_prio, 0);
    int_ack = 1; cyc();
    chk("R4 sup", super_mode, 1); chk("R4 prio", cur_prio, 5);
    int_rte = 1; cyc();
    chk("R5 back to user", super_mode, 0); chk("R5 prio", cur_prio, 0);
    wr(2'd2, 5'b00001);
    chk("R9 en write ignored", glob_en, 0);
    int_rte = 1; cyc();
    chk("R5 empty pop ignored", cur_prio, 0); chk("R5 empty pop sup", super_mode, 0);
    int_ack = 1; cyc();
    chk("R4 ack without irq ignored", super_mode, 0);
    nmi_take();
    chk("R7 nmi prio", cur_prio, 7); chk("R7 nmi cleared", irq_req, 0);
    wr(2'd0, 5'b11111);
    chk("R1 clear", pending, 0);
    src_req = 5'b00001; wr_en = 1; wr_sel = 2'd0; wr_data = 5'b00001; cyc();
    chk("R1 set beats clear", pending[0], 1);
    nmi_take(); nmi_take(); nmi_take();
    chk("R8 full no err", stack_err, 0);
    nmi_take();
    chk("R8 overflow err", stack_err, 1); chk("R8 prio", cur_prio, 7);
    repeat (3) cyc();
    chk("R8 sticky", stack_err, 1);

    rst = 1; cyc(); rst = 0; cyc();
    chk("R10 after reset", stack_err, 0);
    for (int k = 0; k < 4000; k++) begin
      src_req = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
      nmi_req = (($urandom % 40) == 0);
      int_ack = irq_req && (($urandom % 3) == 0);
      int_rte = !int_ack && (($urandom % 6) == 0);
      wr_en   = (($urandom % 5) == 0);
      wr_sel  = 2'($urandom);
      wr_data = N'($urandom);
      if (wr_sel == 2'd2) wr_data[1] = ($urandom % 4) != 0;
      if (wr_sel == 2'd1) wr_data = wr_data | N'($urandom);
      cyc();
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule